// File: doc/BRIEF.md
# Dual-Context CRC Bus Peripheral

A memory-mapped slave that keeps two independent CRC calculations side by side behind one 32-bit register port. Each context owns a configuration register, a seed/running-value register, an input-data register and a result register, plus a private CRC engine. Software or a DMA engine streams message bytes into a context's input register. Each write may be a byte, a half-word or a word, and successive writes may use different sizes. Writes to the two contexts may be interleaved in any order.

Every access completes through a simple request/ready handshake. The interface rejects unsupported byte-enable patterns and unmapped or misaligned addresses with a one-cycle transfer error. It stalls a seed or result read by two wait states when that read follows a write to the same context in the previous cycle. Each context starts at byte offset 16*n, with configuration at +0, seed/running value at +4, input data at +8 and result at +12. The address window is 2^ADDR_W bytes, and everything above NUM_CTX*16 is unmapped.

Top module: `crc_mc_top`

## Requirements
- R1: The legal byte-enable patterns are 4'b1111, 4'b1100, 4'b0011, 4'b0001, 4'b0010, 4'b0100 and 4'b1000, and they are accepted for reads and writes on every register. Any other pattern, including 4'b0000, makes bus_err high.
- R2: An access with bus_addr[1:0] != 0, or with an address at or above NUM_CTX*16, makes bus_err high.
- R3: An errored access completes with zero wait states, changes no register, and returns bus_rdata = 0. bus_err is high only in the cycle where bus_ready and bus_req are both high.
- R4: Every write completes with zero wait states. Every read of a configuration or input register also completes with zero wait states.
- R5: A read of the seed (+4) or result (+12) register takes 3 cycles (2 wait states) when a legal write to the configuration, seed or input register of the same context completed in the previous cycle. A write to the result register does not trigger the stall. Every other read takes zero wait states.
- R6: Configuration bits [1:0] select the polynomial: 0 gives CRC-32 (0x04C11DB7), 1 gives CRC-16 (0x1021), and 2 or 3 give CRC-8 (0x07). Bit 2 reverses the bit order of each input byte before it is folded in. Bit 3 inverts the result. Only byte lane 0 writes the configuration, and bits [31:4] read as 0.
- R7: A seed write merges the enabled bytes into the running CRC, masked to the selected width. A seed read returns the running CRC masked to the width, with the upper bits zero.
- R8: An input write folds the enabled lanes into the CRC in one cycle, lane 3 first down to lane 0. The algorithm is MSB-first and non-reflected. Any mix of byte, half-word and word writes gives the same CRC as the equivalent byte stream. The input register reads as 0.
- R9: The result register returns the running CRC, XORed with the all-ones mask of the selected width when inversion is set. Writes to the result register are accepted but have no effect.
- R10: Accesses to one context never change the other context's registers or CRC.
- R11: After reset, every configuration and running CRC is 0, and bus_rdata is 0 for any access that is not a completed legal read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held until bus_ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables, bit n = lane n (bits 8n+7:8n) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_ready is high |
| bus_ready | output | 1 | Access completes this cycle |
| bus_err | output | 1 | Transfer error for the completing access |

## Verification
The checker assumes that the master holds bus_req, bus_we, bus_addr, bus_be and bus_wdata steady from the start of an access until bus_ready. Without that, the wait-state counter could attach to a different register than the one being stalled. The bench drives each access just after a rising edge and changes fields only after a completing edge. Back-to-back accesses keep bus_req high to create the read-after-write case. The expected CRC values come from an independent bit-serial model, checked against published check values for the string "123456789".

// File: rtl/crc_mc_pkg.sv
package crc_mc_pkg;

   localparam int CTX_BYTES = 16;

   typedef enum logic [1:0] {
      REG_CFG  = 2'd0,
      REG_SEED = 2'd1,
      REG_DIN  = 2'd2,
      REG_RES  = 2'd3
   } reg_e;

   function automatic int width_of(input logic [1:0] sel);
      case (sel)
         2'd0:    return 32;
         2'd1:    return 16;
         default: return 8;
      endcase
   endfunction

   function automatic logic [31:0] poly_of(input logic [1:0] sel);
      case (sel)
         2'd0:    return 32'h04C1_1DB7;
         2'd1:    return 32'h0000_1021;
         default: return 32'h0000_0007;
      endcase
   endfunction

   function automatic logic [31:0] mask_of(input logic [1:0] sel);
      case (sel)
         2'd0:    return 32'hFFFF_FFFF;
         2'd1:    return 32'h0000_FFFF;
         default: return 32'h0000_00FF;
      endcase
   endfunction

   function automatic logic [7:0] bitrev8(input logic [7:0] b);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = b[7-i];
      return r;
   endfunction

   // Left-justify the register so one 32-bit shifter serves every width.
   function automatic logic [31:0] fold_byte(input logic [31:0] crc,
                                             input logic [7:0]  b,
                                             input logic [1:0]  sel);
      logic [31:0] c, p;
      logic        fb;
      int          sh;
      sh = 32 - width_of(sel);
      c  = crc << sh;
      p  = poly_of(sel) << sh;
      for (int i = 7; i >= 0; i--) begin
         fb = c[31] ^ b[i];
         c  = c << 1;
         if (fb) c = c ^ p;
      end
      return c >> sh;
   endfunction

endpackage

// File: rtl/crc_mc_bus.sv
module crc_mc_bus
   import crc_mc_pkg::*;
#(
   parameter int NUM_CTX   = 2,
   parameter int ADDR_W    = 6,
   parameter int RAW_WAITS = 2,
   localparam int CIW      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
   localparam int WCW      = $clog2(RAW_WAITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [3:0]        be,
   output logic              ready,
   output logic              err,
   output logic              wr_fire,
   output logic              rd_fire,
   output logic [CIW-1:0]    ctx,
   output reg_e              rsel
);
   localparam int MAP_BYTES = NUM_CTX * CTX_BYTES;

   logic           be_ok, addr_ok, acc_ok, stall_kind, hazard, in_stall;
   logic           last_wr_v;
   logic [CIW-1:0] last_wr_ctx;
   logic [WCW-1:0] wcnt;

   assign be_ok   = be inside {4'b1111, 4'b1100, 4'b0011,
                               4'b0001, 4'b0010, 4'b0100, 4'b1000};
   assign addr_ok = (addr[1:0] == 2'b00) && (int'(addr) < MAP_BYTES);
   assign acc_ok  = req && be_ok && addr_ok;
   assign ctx     = addr[4 +: CIW];
   assign rsel    = reg_e'(addr[3:2]);

   assign stall_kind = acc_ok && !we && (rsel == REG_SEED || rsel == REG_RES);
   assign hazard     = last_wr_v && (last_wr_ctx == ctx);
   assign in_stall   = stall_kind && (wcnt != '0 || hazard);

   assign ready   = req && (!in_stall || wcnt == WCW'(RAW_WAITS));
   assign err     = req && !(be_ok && addr_ok);
   assign wr_fire = acc_ok && we;
   assign rd_fire = acc_ok && !we && ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt        <= '0;
         last_wr_v   <= 1'b0;
         last_wr_ctx <= '0;
      end else begin
         if (in_stall && wcnt != WCW'(RAW_WAITS)) wcnt <= wcnt + 1'b1;
         else                                     wcnt <= '0;
         last_wr_v   <= wr_fire && (rsel != REG_RES);
         last_wr_ctx <= ctx;
      end
   end
endmodule

// File: rtl/crc_mc_ctx.sv
module crc_mc_ctx
   import crc_mc_pkg::*;
#(
   parameter logic [31:0] SEED_RST = 32'h0,
   parameter logic [3:0]  CFG_RST  = 4'h0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  reg_e        wsel,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   output logic [3:0]  cfg,
   output logic [31:0] cur_crc,
   output logic [31:0] result
);
   logic [3:0]  cfg_q;
   logic [31:0] crc_q, folded, seeded, msk;

   assign msk = mask_of(cfg_q[1:0]);

   always_comb begin
      folded = crc_q;
      for (int ln = 3; ln >= 0; ln--) begin
         if (be[ln])
            folded = fold_byte(folded,
                               cfg_q[2] ? bitrev8(wdata[8*ln +: 8]) : wdata[8*ln +: 8],
                               cfg_q[1:0]);
      end
   end

   always_comb begin
      for (int ln = 0; ln < 4; ln++)
         seeded[8*ln +: 8] = be[ln] ? wdata[8*ln +: 8] : crc_q[8*ln +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RST;
         crc_q <= SEED_RST;
      end else if (wr_en) begin
         case (wsel)
            REG_CFG:  if (be[0]) cfg_q <= wdata[3:0];
            REG_SEED: crc_q <= seeded & msk;
            REG_DIN:  crc_q <= folded;
            default:  ;
         endcase
      end
   end

   assign cfg     = cfg_q;
   assign cur_crc = crc_q & msk;
   assign result  = cur_crc ^ (cfg_q[3] ? msk : 32'h0);
endmodule

// File: rtl/crc_mc_top.sv
module crc_mc_top
   import crc_mc_pkg::*;
#(
   parameter int NUM_CTX   = 2,
   parameter int ADDR_W    = 6,
   parameter int RAW_WAITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_be,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_ready,
   output logic              bus_err
);
   localparam int CIW = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

   initial begin
      assert (NUM_CTX >= 1 && NUM_CTX <= 16)
         else $error("crc_mc_top: NUM_CTX out of range");
      assert (ADDR_W >= 4 + CIW && ADDR_W < 31 && (1 << ADDR_W) >= NUM_CTX * CTX_BYTES)
         else $error("crc_mc_top: ADDR_W too small for the context map");
      assert (RAW_WAITS >= 1 && RAW_WAITS <= 7)
         else $error("crc_mc_top: RAW_WAITS out of range");
   end

   logic           wr_fire, rd_fire;
   logic [CIW-1:0] ctx;
   reg_e           rsel;

   logic [3:0]  cfg_a [NUM_CTX];
   logic [31:0] crc_a [NUM_CTX];
   logic [31:0] res_a [NUM_CTX];

   crc_mc_bus #(
      .NUM_CTX   (NUM_CTX),
      .ADDR_W    (ADDR_W),
      .RAW_WAITS (RAW_WAITS)
   ) u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (bus_req),
      .we      (bus_we),
      .addr    (bus_addr),
      .be      (bus_be),
      .ready   (bus_ready),
      .err     (bus_err),
      .wr_fire (wr_fire),
      .rd_fire (rd_fire),
      .ctx     (ctx),
      .rsel    (rsel)
   );

   for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      crc_mc_ctx u_ctx (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_fire && (int'(ctx) == c)),
         .wsel    (rsel),
         .be      (bus_be),
         .wdata   (bus_wdata),
         .cfg     (cfg_a[c]),
         .cur_crc (crc_a[c]),
         .result  (res_a[c])
      );
   end

   always_comb begin
      bus_rdata = 32'h0;
      if (rd_fire && int'(ctx) < NUM_CTX) begin
         case (rsel)
            REG_CFG:  bus_rdata = {28'h0, cfg_a[ctx]};
            REG_SEED: bus_rdata = crc_a[ctx];
            REG_RES:  bus_rdata = res_a[ctx];
            default:  bus_rdata = 32'h0;
         endcase
      end
   end
endmodule

// File: rtl/crc_mc_chk.sv
module crc_mc_chk #(
   parameter int ADDR_W    = 6,
   parameter int RAW_WAITS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [3:0]        bus_be,
   input logic [31:0]       bus_rdata,
   input logic              bus_ready,
   input logic              bus_err
);
   logic [3:0] stall_run;
   logic       be_legal;

   assign be_legal = bus_be inside {4'b1111, 4'b1100, 4'b0011,
                                    4'b0001, 4'b0010, 4'b0100, 4'b1000};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      stall_run <= '0;
      else if (bus_req && !bus_ready)  stall_run <= stall_run + 1'b1;
      else                             stall_run <= '0;
   end

   // R3
   err_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (bus_ready && bus_req));

   // R3
   err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (bus_rdata == 32'h0));

   // R1
   bad_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !be_legal) |-> bus_err);

   // R2
   misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_addr[1:0] != 2'b00) |-> bus_err);

   // R4
   write_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we) |-> bus_ready);

   // R5
   stall_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ready) |-> (!bus_we && bus_addr[2] == 1'b1));

   // R5
   stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ready) |-> (int'(stall_run) < RAW_WAITS));

   // R11
   idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ready |-> (bus_rdata == 32'h0));
endmodule

bind crc_mc_top crc_mc_chk #(.ADDR_W(ADDR_W), .RAW_WAITS(RAW_WAITS)) u_chk (.*);

// File: tb/tb_crc_mc_top.sv
`timescale 1ns/1ps
module tb_crc_mc_top;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_req = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [3:0]    bus_be = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          bus_ready;
   logic          bus_err;

   always #2 clk = ~clk;   // 250 MHz

   crc_mc_top dut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err)
   );

   typedef struct {
      logic [31:0] rd;
      logic        er;
      int          waits;
      string       tag;
   } exp_t;

   exp_t  sb[$];
   int    n_chk = 0;
   int    n_fail = 0;
   int    wait_seen = 0;
   bit    finished = 0;

   // independent bit-serial reference model
   logic [3:0]  m_cfg [2];
   logic [31:0] m_crc [2];

   function automatic int m_width(logic [1:0] s);
      return (s == 2'd0) ? 32 : (s == 2'd1) ? 16 : 8;
   endfunction
   function automatic logic [31:0] m_mask(logic [1:0] s);
      return (s == 2'd0) ? 32'hFFFFFFFF : (s == 2'd1) ? 32'h0000FFFF : 32'h000000FF;
   endfunction
   function automatic logic [31:0] m_poly(logic [1:0] s);
      return (s == 2'd0) ? 32'h04C11DB7 : (s == 2'd1) ? 32'h00001021 : 32'h00000007;
   endfunction
   function automatic logic [31:0] m_fold(logic [31:0] crc, logic [7:0] b, logic [3:0] cfg);
      logic [31:0] c;
      logic [7:0]  d;
      logic        fb;
      int          w;
      w = m_width(cfg[1:0]);
      for (int i = 0; i < 8; i++) d[i] = cfg[2] ? b[7-i] : b[i];
      c = crc & m_mask(cfg[1:0]);
      for (int i = 7; i >= 0; i--) begin
         fb = c[w-1] ^ d[i];
         c  = (c << 1) & m_mask(cfg[1:0]);
         if (fb) c = c ^ m_poly(cfg[1:0]);
      end
      return c;
   endfunction

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && bus_req) begin
         if (!bus_ready) wait_seen++;
         else begin
            exp_t e;
            if (sb.size() == 0) begin
               n_chk++; n_fail++;
               $display("FAIL unexpected completion: actual rdata=%h expected none", bus_rdata);
            end else begin
               e = sb.pop_front();
               n_chk++;
               if (bus_rdata !== e.rd || bus_err !== e.er || wait_seen != e.waits) begin
                  n_fail++;
                  $display("FAIL %s: actual rdata=%h err=%b waits=%0d expected rdata=%h err=%b waits=%0d",
                           e.tag, bus_rdata, bus_err, wait_seen, e.rd, e.er, e.waits);
               end
            end
            wait_seen = 0;
         end
      end
   end

   task automatic xfer(bit w, logic [AW-1:0] a, logic [3:0] b, logic [31:0] d,
                       logic [31:0] erd, bit eer, int ew, string tag);
      exp_t e;
      e.rd = erd; e.er = eer; e.waits = ew; e.tag = tag;
      sb.push_back(e);
      bus_req = 1'b1; bus_we = w; bus_addr = a; bus_be = b; bus_wdata = d;
      do @(negedge clk); while (!bus_ready);
      @(posedge clk); #1;
   endtask

   task automatic idle();
      bus_req = 1'b0; bus_we = 1'b0; bus_be = '0;
      @(posedge clk); #1;
   endtask

   function automatic logic [AW-1:0] ad(int c, int r);
      return AW'(c * 16 + r * 4);
   endfunction

   task automatic wr(int c, int r, logic [3:0] b, logic [31:0] d, string tag);
      case (r)
         0: if (b[0]) m_cfg[c] = d[3:0];
         1: begin
            logic [31:0] s;
            for (int ln = 0; ln < 4; ln++) s[8*ln +: 8] = b[ln] ? d[8*ln +: 8] : m_crc[c][8*ln +: 8];
            m_crc[c] = s & m_mask(m_cfg[c][1:0]);
         end
         2: for (int ln = 3; ln >= 0; ln--)
               if (b[ln]) m_crc[c] = m_fold(m_crc[c], d[8*ln +: 8], m_cfg[c]);
         default: ;
      endcase
      xfer(1'b1, ad(c, r), b, d, 32'h0, 1'b0, 0, tag);
   endtask

   function automatic logic [31:0] m_read(int c, int r);
      logic [31:0] v;
      v = m_crc[c] & m_mask(m_cfg[c][1:0]);
      case (r)
         0: return {28'h0, m_cfg[c]};
         1: return v;
         3: return m_cfg[c][3] ? (v ^ m_mask(m_cfg[c][1:0])) : v;
         default: return 32'h0;
      endcase
   endfunction

   task automatic rd(int c, int r, int ew, string tag);
      xfer(1'b0, ad(c, r), 4'b1111, 32'h0, m_read(c, r), 1'b0, ew, tag);
   endtask

   task automatic feed_check(int c);   // "123456789" as mixed sizes
      wr(c, 2, 4'b1111, 32'h31323334, "R8 word");
      wr(c, 2, 4'b1100, 32'h3536AAAA, "R8 high half");
      wr(c, 2, 4'b0001, 32'hBBBBBB37, "R8 byte lane0");
      wr(c, 2, 4'b0011, 32'hCCCC3839, "R8 low half");
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung run expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 2; c++) begin m_cfg[c] = 4'h0; m_crc[c] = 32'h0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R11 reset state
      rd(0, 0, 0, "R11 cfg0 reset");
      rd(0, 1, 0, "R11 seed0 reset");
      rd(1, 3, 0, "R11 res1 reset");
      idle();

      // R6 R7 setup: ctx0 CRC-32 seed all ones, ctx1 CRC-16 seed all ones
      wr(0, 0, 4'b1111, 32'h0, "R6 cfg0 crc32");
      wr(1, 0, 4'b0001, 32'h1, "R6 cfg1 crc16");
      wr(0, 1, 4'b1111, 32'hFFFFFFFF, "R7 seed0");
      wr(1, 1, 4'b1111, 32'hFFFFFFFF, "R7 seed1");
      idle();
      rd(1, 1, 0, "R7 seed1 masked to 16 bits");
      idle();

      // R10 interleaved streams
      wr(0, 2, 4'b1111, 32'h31323334, "R10 ctx0 word");
      wr(1, 2, 4'b1000, 32'h31000000, "R10 ctx1 byte lane3");
      wr(1, 2, 4'b0100, 32'h00320000, "R10 ctx1 byte lane2");
      wr(0, 2, 4'b1100, 32'h35360000, "R10 ctx0 half");
      wr(1, 2, 4'b0011, 32'h00003334, "R10 ctx1 half");
      wr(0, 2, 4'b0001, 32'h00000037, "R10 ctx0 byte");
      wr(1, 2, 4'b1111, 32'h35363738, "R10 ctx1 word");
      wr(0, 2, 4'b0011, 32'h00003839, "R10 ctx0 half");
      wr(1, 2, 4'b0010, 32'h00003900, "R10 ctx1 byte lane1");
      // R5 read of other context right after a write: no stall; R8 check value
      xfer(1'b0, ad(0, 3), 4'b1111, 0, 32'h0376E6E7, 1'b0, 0, "R8 crc32 check value");
      idle();
      xfer(1'b0, ad(1, 3), 4'b1111, 0, 32'h000029B1, 1'b0, 0, "R8 crc16 check value");
      idle();

      // R5 stalls
      wr(0, 2, 4'b0001, 32'h00000055, "R5 din write");
      rd(0, 1, 2, "R5 seed read after din write");
      rd(0, 3, 0, "R5 result read after read");
      idle();
      wr(1, 0, 4'b0001, 32'h00000002, "R5 cfg write");
      rd(1, 3, 2, "R5 result read after cfg write");
      idle();
      wr(1, 1, 4'b1111, 32'h0, "R5 seed write");
      rd(1, 1, 2, "R5 seed read after seed write");
      wr(0, 0, 4'b0001, 32'h0, "R4 cfg write");
      rd(0, 0, 0, "R4 cfg read after write");
      wr(0, 3, 4'b1111, 32'h12345678, "R9 result write");
      rd(0, 3, 0, "R9 result write ignored, no stall");
      wr(0, 2, 4'b1000, 32'h77000000, "R4 din write");
      rd(0, 2, 0, "R4 R8 din read zero, no stall");
      idle();

      // R6 CRC-8 check value (ctx1 now CRC-8, seed 0)
      feed_check(1);
      idle();
      xfer(1'b0, ad(1, 3), 4'b1111, 0, 32'h000000F4, 1'b0, 0, "R6 crc8 check value");
      idle();

      // R6 R9 reflected input with inverted output on CRC-32
      wr(0, 0, 4'b0001, 32'h0000000C, "R6 cfg swap+invert");
      wr(0, 1, 4'b1111, 32'hFFFFFFFF, "R7 seed0 reload");
      feed_check(0);
      idle();
      rd(0, 3, 0, "R9 inverted result");
      rd(0, 1, 0, "R9 running value not inverted");
      rd(0, 0, 0, "R6 cfg readback");
      idle();

      // R7 partial seed write on a 32-bit context
      wr(1, 0, 4'b0001, 32'h0, "R7 cfg1 crc32");
      wr(1, 1, 4'b1111, 32'h0, "R7 clear seed1");
      wr(1, 1, 4'b1100, 32'hABCD9999, "R7 high-half seed");
      idle();
      rd(1, 1, 0, "R7 merged seed");
      idle();

      // R1 R2 R3 errors
      xfer(1'b1, ad(0, 1), 4'b0101, 32'h12345678, 32'h0, 1'b1, 0, "R1 be 0101 write");
      rd(0, 1, 0, "R3 seed unchanged after error, no stall");
      xfer(1'b0, ad(0, 0), 4'b0000, 0, 32'h0, 1'b1, 0, "R1 be 0000 read");
      xfer(1'b1, ad(1, 2), 4'b0110, 32'hFFFFFFFF, 32'h0, 1'b1, 0, "R1 be 0110 write");
      xfer(1'b0, AW'(32), 4'b1111, 0, 32'h0, 1'b1, 0, "R2 unmapped read");
      xfer(1'b1, AW'(60), 4'b1111, 32'h1, 32'h0, 1'b1, 0, "R2 unmapped write");
      xfer(1'b1, AW'(6), 4'b0001, 32'hFF, 32'h0, 1'b1, 0, "R2 misaligned write");
      idle();
      rd(1, 1, 0, "R3 R10 ctx1 unchanged after errors");
      xfer(1'b0, ad(0, 0), 4'b0011, 0, {28'h0, m_cfg[0]}, 1'b0, 0, "R1 half-word read legal");
      xfer(1'b0, ad(0, 0), 4'b0100, 0, {28'h0, m_cfg[0]}, 1'b0, 0, "R1 byte read legal");
      idle();
      repeat (3) @(posedge clk);

      if (sb.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
      end
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule